// File: doc/BRIEF.md
# Interrupt Page Context Stack

This block holds the register-page selection for an 8051-style core as a three-deep stack of byte-wide page numbers. Entry 0 is the page currently in use and drives the page-select output. Entry 1 is the page to go back to on the next return from interrupt. Entry 2 is the page after that.

When the interrupt controller accepts an interrupt, it pulses an accept strobe together with the page that holds that source's flag. The stack then shifts down one place and the new page becomes current. A return strobe shifts the stack back up, and the freed bottom entry reads as zero. Software can read any entry, and can overwrite any one entry in place, through a small select/data port. Such a write never shifts the stack. The interrupt controller and the register decoder sit outside this block.

Top module: `irq_page_stack`

## Requirements
- R1: After reset all three entries and `cur_page_o` are 0x00.
- R2: An accept pulse (`irq_take_i`) loads entry 0 with `irq_page_i`, moves the old entry 0 into entry 1 and the old entry 1 into entry 2, all visible on the cycle after the strobe. The old entry 2 is discarded.
- R3: A return pulse (`irq_ret_i`) moves entry 1 into entry 0 and entry 2 into entry 1, and clears entry 2 to 0x00, all visible on the cycle after the strobe.
- R4: A software write (`sw_wr_i`) with `sw_sel_i` equal to 0, 1 or 2 replaces only that entry with `sw_wdata_i` on the next cycle and shifts nothing.
- R5: `sw_rdata_o` shows, in the same cycle, the entry chosen by `sw_sel_i` (0 = current, 1 = next, 2 = last). Select value 3 reads 0x00.
- R6: A software write with `sw_sel_i` = 3 leaves every entry unchanged.
- R7: When a software write falls in the same cycle as an accept or a return pulse, the shift is carried out and the write is dropped.
- R8: When accept and return pulse in the same cycle, only the accept (push) takes effect.
- R9: Any 8-bit page value, not only those the device populates (0x00–0x03, 0x0F), is stored and shifted unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_take_i | input | 1 | Interrupt accepted: push |
| irq_page_i | input | 8 | Page tied to the accepted interrupt source |
| irq_ret_i | input | 1 | Return from interrupt: pop |
| sw_wr_i | input | 1 | Software write strobe |
| sw_sel_i | input | 2 | Entry select for software read and write |
| sw_wdata_i | input | 8 | Software write data |
| sw_rdata_o | output | 8 | Selected entry, combinational |
| cur_page_o | output | 8 | Current page (entry 0) |

## Verification
The assertions assume that every strobe is a single-cycle pulse sampled on the clock edge, and that the page and write data are stable at that edge. They also assume that no check needs to look back past reset. The stimulus sets up each pulse at the falling edge, holds it through exactly one rising edge, and clears it afterwards. Only the collision tests raise two strobes at once, and they do so on purpose so that the priority between strobes is exercised.

// File: rtl/page_stack_pkg.sv
package page_stack_pkg;

    localparam int unsigned PAGE_W = 8;
    localparam int unsigned DEPTH  = 3;
    localparam int unsigned SEL_W  = (DEPTH > 1) ? $clog2(DEPTH + 1) : 1;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_WRITE = 2'd3
    } stack_op_e;

    typedef struct packed {
        logic [DEPTH-1:0][PAGE_W-1:0] ent;
    } stack_t;

endpackage

// File: rtl/page_op_decode.sv
module page_op_decode
    import page_stack_pkg::*;
(
    input  logic             take_i,
    input  logic             ret_i,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] sel_i,
    output stack_op_e        op_o
);

    logic sel_ok;

    always_comb begin
        sel_ok = (int'(sel_i) < int'(DEPTH));
        if (take_i) begin
            op_o = OP_PUSH;
        end else if (ret_i) begin
            op_o = OP_POP;
        end else if (wr_i && sel_ok) begin
            op_o = OP_WRITE;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/page_stack_core.sv
module page_stack_core
    import page_stack_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  stack_op_e         op_i,
    input  logic [PAGE_W-1:0] push_page_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [PAGE_W-1:0] wr_data_i,
    output stack_t            st_o
);

    stack_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_PUSH: begin
                for (int i = DEPTH - 1; i > 0; i--) begin
                    st_d.ent[i] = st_q.ent[i-1];
                end
                st_d.ent[0] = push_page_i;
            end
            OP_POP: begin
                for (int i = 0; i < int'(DEPTH) - 1; i++) begin
                    st_d.ent[i] = st_q.ent[i+1];
                end
                st_d.ent[DEPTH-1] = '0;
            end
            OP_WRITE: begin
                for (int i = 0; i < int'(DEPTH); i++) begin
                    if (wr_sel_i == SEL_W'(i)) begin
                        st_d.ent[i] = wr_data_i;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

    // R2
    push_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == OP_PUSH |=> st_q.ent[0] == $past(push_page_i)
                         && st_q.ent[1] == $past(st_q.ent[0])
                         && st_q.ent[2] == $past(st_q.ent[1]));

    // R3
    pop_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == OP_POP |=> st_q.ent[0] == $past(st_q.ent[1])
                        && st_q.ent[1] == $past(st_q.ent[2])
                        && st_q.ent[2] == '0);

    // R4
    single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_WRITE && wr_sel_i == 2'd1) |=> st_q.ent[1] == $past(wr_data_i)
                                                && $stable(st_q.ent[0])
                                                && $stable(st_q.ent[2]));

endmodule

// File: rtl/page_read_mux.sv
module page_read_mux
    import page_stack_pkg::*;
(
    input  stack_t            st_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [PAGE_W-1:0] data_o
);

    always_comb begin
        data_o = '0;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (sel_i == SEL_W'(i)) begin
                data_o = st_i.ent[i];
            end
        end
    end

endmodule

// File: rtl/irq_page_stack.sv
module irq_page_stack
    import page_stack_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              irq_take_i,
    input  logic [PAGE_W-1:0] irq_page_i,
    input  logic              irq_ret_i,
    input  logic              sw_wr_i,
    input  logic [SEL_W-1:0]  sw_sel_i,
    input  logic [PAGE_W-1:0] sw_wdata_i,
    output logic [PAGE_W-1:0] sw_rdata_o,
    output logic [PAGE_W-1:0] cur_page_o
);

    stack_op_e op;
    stack_t    st;

    page_op_decode u_dec (
        .take_i (irq_take_i),
        .ret_i  (irq_ret_i),
        .wr_i   (sw_wr_i),
        .sel_i  (sw_sel_i),
        .op_o   (op)
    );

    page_stack_core u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_i        (op),
        .push_page_i (irq_page_i),
        .wr_sel_i    (sw_sel_i),
        .wr_data_i   (sw_wdata_i),
        .st_o        (st)
    );

    page_read_mux u_rd (
        .st_i   (st),
        .sel_i  (sw_sel_i),
        .data_o (sw_rdata_o)
    );

    assign cur_page_o = st.ent[0];

    // R6
    bad_sel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_wr_i && int'(sw_sel_i) >= int'(DEPTH) && !irq_take_i && !irq_ret_i)
        |=> $stable(st));

    // R7
    write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_wr_i && irq_ret_i && !irq_take_i) |=> cur_page_o == $past(st.ent[1]));

    // R8
    take_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_take_i |=> cur_page_o == $past(irq_page_i));

endmodule

// File: tb/irq_page_stack_bench.sv
module irq_page_stack_bench;

    localparam time HALF = 2.5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       take = 1'b0;
    logic [7:0] page = '0;
    logic       ret = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] sel = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] cur;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_e [3];

    always #HALF clk = ~clk;

    irq_page_stack u_irq_page_stack (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .irq_take_i (take),
        .irq_page_i (page),
        .irq_ret_i  (ret),
        .sw_wr_i    (wr),
        .sw_sel_i   (sel),
        .sw_wdata_i (wdata),
        .sw_rdata_o (rdata),
        .cur_page_o (cur)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, want);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, cur, exp_e[0]);
        for (int i = 0; i < 3; i++) begin
            sel = 2'(i);
            #0.1ns;
            chk(req, rdata, exp_e[i]);
        end
    endtask

    task automatic cycle(input logic t, input logic [7:0] p, input logic r,
                         input logic w, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        take = t; page = p; ret = r; wr = w; sel = s; wdata = d;
        @(posedge clk);
        #1ns;
        take = 1'b0; ret = 1'b0; wr = 1'b0;
    endtask

    task automatic set_exp(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        exp_e[0] = a; exp_e[1] = b; exp_e[2] = c;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1ns;
        rst_n = 1'b1;
        set_exp(8'h00, 8'h00, 8'h00);
        check_all("R1");
    endtask

    task automatic t_push_chain;
        cycle(1, 8'h01, 0, 0, 0, 0); set_exp(8'h01, 8'h00, 8'h00); check_all("R2");
        cycle(1, 8'h0F, 0, 0, 0, 0); set_exp(8'h0F, 8'h01, 8'h00); check_all("R2");
        cycle(1, 8'h02, 0, 0, 0, 0); set_exp(8'h02, 8'h0F, 8'h01); check_all("R2");
        cycle(1, 8'hC3, 0, 0, 0, 0); set_exp(8'hC3, 8'h02, 8'h0F); check_all("R9 page kept");
    endtask

    task automatic t_pop_chain;
        cycle(0, 0, 1, 0, 0, 0); set_exp(8'h02, 8'h0F, 8'h00); check_all("R3");
        cycle(0, 0, 1, 0, 0, 0); set_exp(8'h0F, 8'h00, 8'h00); check_all("R3");
    endtask

    task automatic t_sw_write;
        cycle(0, 0, 0, 1, 2'd1, 8'hA5); set_exp(8'h0F, 8'hA5, 8'h00); check_all("R4");
        cycle(0, 0, 0, 1, 2'd2, 8'h3C); set_exp(8'h0F, 8'hA5, 8'h3C); check_all("R4");
        cycle(0, 0, 0, 1, 2'd0, 8'h77); set_exp(8'h77, 8'hA5, 8'h3C); check_all("R4");
    endtask

    task automatic t_bad_sel;
        cycle(0, 0, 0, 1, 2'd3, 8'hEE);
        check_all("R6");
        sel = 2'd3;
        #0.1ns;
        chk("R5 sel3 reads zero", rdata, 8'h00);
    endtask

    task automatic t_collide;
        cycle(1, 8'h01, 0, 1, 2'd0, 8'h99); set_exp(8'h01, 8'h77, 8'hA5); check_all("R7 push");
        cycle(1, 8'h02, 1, 0, 0, 0);        set_exp(8'h02, 8'h01, 8'h77); check_all("R8");
        cycle(0, 0, 1, 1, 2'd2, 8'h55);     set_exp(8'h01, 8'h77, 8'h00); check_all("R7 pop");
    endtask

    initial begin
        t_reset();
        t_push_chain();
        t_pop_chain();
        t_sw_write();
        t_bad_sel();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(HALF * 2 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule